// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block sits beside a floating-point unit and collects the per-operation status the unit produces into a set of sticky exception flags. Each completed operation presents a thirteen-bit cause vector with a valid strobe. While the exception-enable input is high, the causes are folded into eight flag bits. Several distinct invalid-operation causes share the invalid flag, and some of them also set a more specific flag. The flags stay set until software overwrites them through the register write port.

After each qualifying strobe the block raises a one-cycle exception request whenever any flag is set in the updated register. The core's trap logic consumes this request. The cause stream has a valid/ready handshake, but the accumulator can take a strobe every cycle. `st_ready` is therefore always high, and the producer never sees back-pressure. The cause vector is sampled only on a cycle with `st_valid` high.

Cause bit positions in `st_cause`:

| Bit | Cause |
|-----|-------|
| 0 | signaling NaN |
| 1 | quiet NaN |
| 2 | infinity minus infinity |
| 3 | infinity over infinity |
| 4 | zero over zero |
| 5 | infinity times zero |
| 6 | invalid conversion |
| 7 | invalid compare |
| 8 | invalid square root |
| 9 | divide by zero |
| 10 | overflow |
| 11 | underflow |
| 12 | inexact |

Flag bit positions in `csr_flags` and `csr_wdata`:

| Bit | Flag |
|-----|------|
| 0 | invalid |
| 1 | SNaN |
| 2 | QNaN |
| 3 | overflow |
| 4 | underflow |
| 5 | infinity |
| 6 | divide by zero |
| 7 | inexact |

Top module: `fpx_flag_accum`

## Requirements
- R1: While `rst_n` is low, `csr_flags` is 0 and `exc_req` is 0.
- R2: If `exc_en` is low, a strobe changes no flag and raises no request. A cycle with `st_valid` low is treated the same way, whatever `st_cause` holds.
- R3: With `exc_en` high, any of cause bits 0 to 8 sets flag bit 0 (invalid).
- R4: With `exc_en` high, cause bit 0 also sets flag bit 1 (SNaN), and cause bit 1 also sets flag bit 2 (QNaN).
- R5: With `exc_en` high, cause bit 2 or cause bit 3 also sets flag bit 5 (infinity).
- R6: With `exc_en` high, each of the following causes sets its own flag:
  - cause 10 (overflow) sets flag 3;
  - cause 11 (underflow) sets flag 4;
  - cause 9 (divide by zero) sets flag 6;
  - cause 12 (inexact) sets flag 7.
- R7: `exc_req` is high for exactly the one cycle after each qualifying strobe (`st_valid` and `exc_en` both high), and only when the updated flags are nonzero. Back-to-back qualifying strobes give back-to-back request cycles.
- R8: Flags are sticky. An update only ORs new bits in, and flags clear only when `csr_we` loads `csr_wdata`.
- R9: When a write and a qualifying strobe share a cycle, the register becomes `csr_wdata` ORed with the mapped causes.
- R10: `st_ready` is always high. Flag updates appear on `csr_flags` one clock after the strobe or write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Cause vector valid |
| st_ready | output | 1 | Always high; no back-pressure |
| st_cause | input | 13 | Per-operation cause vector |
| exc_en | input | 1 | Exception enable |
| csr_we | input | 1 | Flag register write strobe |
| csr_wdata | input | 8 | Flag register write data |
| csr_flags | output | 8 | Current flag register |
| exc_req | output | 1 | One-cycle exception request |

## Verification
Both `csr_flags` and `exc_req` are registered. Each is due exactly one clock after the edge that samples a strobe or a write. The bench drives inputs on the falling edge and lets one rising edge pass. It deasserts the inputs and reads both outputs at the next falling edge. Where a check covers the single-cycle nature of `exc_req`, the bench waits one more clock and confirms that the request has fallen.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NUM_CAUSE = 13;
  localparam int NUM_FLAG  = 8;

  // cause indices
  localparam int C_SNAN   = 0;
  localparam int C_QNAN   = 1;
  localparam int C_INF_SUB = 2;
  localparam int C_INF_DIV = 3;
  localparam int C_ZDZ    = 4;
  localparam int C_IMZ    = 5;
  localparam int C_CVT    = 6;
  localparam int C_CMP    = 7;
  localparam int C_SQRT   = 8;
  localparam int C_DIVZ   = 9;
  localparam int C_OVER   = 10;
  localparam int C_UNDER  = 11;
  localparam int C_INEX   = 12;

  // flag indices
  localparam int F_INVALID = 0;
  localparam int F_SNAN    = 1;
  localparam int F_QNAN    = 2;
  localparam int F_OVER    = 3;
  localparam int F_UNDER   = 4;
  localparam int F_INF     = 5;
  localparam int F_DIVZ    = 6;
  localparam int F_INEX    = 7;

  typedef logic [NUM_CAUSE-1:0] cause_t;
  typedef logic [NUM_FLAG-1:0]  flags_t;
endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
  import fpx_pkg::*;
(
  input  cause_t cause,
  output flags_t set_bits
);
  localparam int NUM_INV = C_SQRT - C_SNAN + 1;

  logic [NUM_INV-1:0] inv_causes;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_INV; gi++) begin : g_inv
      assign inv_causes[gi] = cause[C_SNAN + gi];
    end
  endgenerate

  always_comb begin
    set_bits            = '0;
    set_bits[F_INVALID] = |inv_causes;
    set_bits[F_SNAN]    = cause[C_SNAN];
    set_bits[F_QNAN]    = cause[C_QNAN];
    set_bits[F_INF]     = cause[C_INF_SUB] | cause[C_INF_DIV];
    set_bits[F_OVER]    = cause[C_OVER];
    set_bits[F_UNDER]   = cause[C_UNDER];
    set_bits[F_DIVZ]    = cause[C_DIVZ];
    set_bits[F_INEX]    = cause[C_INEX];
  end
endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg
  import fpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t set_bits,
  input  logic   we,
  input  flags_t wdata,
  output flags_t flags,
  output flags_t flags_nxt
);
  flags_t base;

  always_comb begin
    base      = we ? wdata : flags;
    flags_nxt = upd ? (base | set_bits) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nxt;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !we) |=> (flags == $past(flags)));

  // R8
  sticky_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/fpx_exc_pulse.sv
module fpx_exc_pulse
  import fpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t flags_nxt,
  output logic   exc_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_req <= 1'b0;
    else        exc_req <= upd && (|flags_nxt);
  end
endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
  import fpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [NUM_CAUSE-1:0] st_cause,
  input  logic                 exc_en,
  input  logic                 csr_we,
  input  logic [NUM_FLAG-1:0]  csr_wdata,
  output logic [NUM_FLAG-1:0]  csr_flags,
  output logic                 exc_req
);
  logic   upd;
  flags_t set_bits;
  flags_t flags_nxt;

  assign st_ready = 1'b1;
  assign upd      = st_valid && st_ready && exc_en;

  fpx_cause_map u_map (
    .cause    (st_cause),
    .set_bits (set_bits)
  );

  fpx_flag_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (upd),
    .set_bits  (set_bits),
    .we        (csr_we),
    .wdata     (csr_wdata),
    .flags     (csr_flags),
    .flags_nxt (flags_nxt)
  );

  fpx_exc_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (upd),
    .flags_nxt (flags_nxt),
    .exc_req   (exc_req)
  );

  // R2
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(st_valid && exc_en)) |=> !exc_req);

  // R3
  invalid_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && exc_en && (|st_cause[C_SQRT:C_SNAN])) |=> csr_flags[F_INVALID]);

  // R4
  snan_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && exc_en && st_cause[C_SNAN]) |=> csr_flags[F_SNAN]);

  // R5
  inf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && exc_en && (st_cause[C_INF_SUB] || st_cause[C_INF_DIV]))
      |=> csr_flags[F_INF]);

  // R7
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (csr_flags != '0));
endmodule

// File: tb/fpx_flag_accum_tb.sv
module fpx_flag_accum_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [12:0] st_cause = '0;
  logic        exc_en = 1'b0;
  logic        csr_we = 1'b0;
  logic [7:0]  csr_wdata = '0;
  logic [7:0]  csr_flags;
  logic        exc_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_flag_accum u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_cause(st_cause), .exc_en(exc_en), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_flags(csr_flags), .exc_req(exc_req)
  );

  // {en, cause[12:0], expected flags[7:0], expected req}, register cleared before each
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 13'h0001, 8'h03, 1'b1},  // R4 snan
    {1'b1, 13'h0002, 8'h05, 1'b1},  // R4 qnan
    {1'b1, 13'h0004, 8'h21, 1'b1},  // R5 inf-inf
    {1'b1, 13'h0008, 8'h21, 1'b1},  // R5 inf/inf
    {1'b1, 13'h0010, 8'h01, 1'b1},  // R3
    {1'b1, 13'h0020, 8'h01, 1'b1},  // R3
    {1'b1, 13'h0040, 8'h01, 1'b1},  // R3
    {1'b1, 13'h0080, 8'h01, 1'b1},  // R3
    {1'b1, 13'h0100, 8'h01, 1'b1},  // R3
    {1'b1, 13'h0200, 8'h40, 1'b1},  // R6 div0
    {1'b1, 13'h0400, 8'h08, 1'b1},  // R6 ovf
    {1'b1, 13'h0800, 8'h10, 1'b1},  // R6 unf
    {1'b1, 13'h1000, 8'h80, 1'b1},  // R6 inexact
    {1'b1, 13'h0000, 8'h00, 1'b0},  // R7 no flag, no req
    {1'b0, 13'h0001, 8'h00, 1'b0},  // R2 disabled
    {1'b1, 13'h1FFF, 8'hFF, 1'b1}   // R3 all causes
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive on falling edge, sample at the next falling edge
  task automatic step(input logic v, input logic [12:0] c, input logic en,
                      input logic we, input logic [7:0] wd);
    st_valid = v; st_cause = c; exc_en = en; csr_we = we; csr_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0; st_cause = '0; csr_we = 1'b0; csr_wdata = '0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 flags in reset", csr_flags, 8'h00);
    check("R1 req in reset", {7'b0, exc_req}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready", {7'b0, st_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      step(1'b0, 13'h0, 1'b0, 1'b1, 8'h00);
      step(1'b1, VEC[i][21:9], VEC[i][22], 1'b0, 8'h00);
      check($sformatf("R3-map vec%0d flags", i), csr_flags, VEC[i][8:1]);
      check($sformatf("R7 vec%0d req", i), {7'b0, exc_req}, {7'b0, VEC[i][0]});
    end

    // sticky accumulation (R8), request from older flag (R7)
    step(1'b0, 13'h0, 1'b0, 1'b1, 8'h00);
    step(1'b1, 13'h0400, 1'b1, 1'b0, 8'h00);
    step(1'b1, 13'h1000, 1'b1, 1'b0, 8'h00);
    check("R8 sticky accumulate", csr_flags, 8'h88);
    step(1'b1, 13'h0000, 1'b1, 1'b0, 8'h00);
    check("R7 req on old flags", {7'b0, exc_req}, 8'h01);
    @(negedge clk);
    check("R7 single-cycle pulse", {7'b0, exc_req}, 8'h00);

    // disabled with flags set (R2)
    step(1'b1, 13'h0200, 1'b0, 1'b0, 8'h00);
    check("R2 disabled flags", csr_flags, 8'h88);
    check("R2 disabled req", {7'b0, exc_req}, 8'h00);
    // valid low ignored (R2)
    step(1'b0, 13'h1FFF, 1'b1, 1'b0, 8'h00);
    check("R2 valid low flags", csr_flags, 8'h88);
    check("R2 valid low req", {7'b0, exc_req}, 8'h00);

    // write + update same cycle (R9)
    step(1'b1, 13'h0200, 1'b1, 1'b1, 8'h08);
    check("R9 write or update", csr_flags, 8'h48);
    // write clears (R8)
    step(1'b0, 13'h0, 1'b1, 1'b1, 8'h00);
    check("R8 write clears", csr_flags, 8'h00);
    check("R8 write no req", {7'b0, exc_req}, 8'h00);

    // back-to-back strobes (R7)
    st_valid = 1'b1; st_cause = 13'h0800; exc_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 back-to-back 1", {7'b0, exc_req}, 8'h01);
    @(posedge clk);
    @(negedge clk);
    check("R7 back-to-back 2", {7'b0, exc_req}, 8'h01);
    st_valid = 1'b0; st_cause = '0;
    @(negedge clk);
    check("R7 falls after", {7'b0, exc_req}, 8'h00);
    check("R6 unf kept", csr_flags, 8'h10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule